// File: doc/BRIEF.md
# Two-Way Set-Associative Lookup with Per-Set Way Prediction

This block is the lookup stage of a two-way set-associative cache. Every set stores a single prediction bit that selects which of its two ways is tried first. When a request is accepted, the stage reads only that way's tag and data, runs one tag comparison, and presents the predicted way's data on an early output before the comparison finishes. If the predicted way matches, the hit is reported one cycle later.

If the predicted way does not match, the stage stops accepting requests. It reads the other way in the next cycle and compares it in the cycle after that. A match there is reported as a slow hit, and the set's prediction bit is retrained to point at that way. If neither way matches, the access is reported as a miss. At most one tag comparator is active in any cycle. Tags, data, valid bits and prediction bits are held in internal register arrays. A fill port installs a line into a chosen way of a chosen set and points that set's predictor at the way just written.

Top module: `waypred_lookup`

## Requirements
- R1: After reset, every line is invalid and every prediction bit is 0. req_ready is 1 and resp_valid is 0. A lookup of any tag, including tag 0, is therefore a slow miss.
- R2: A fill (fill_valid=1 at a clock edge) writes fill_tag and fill_data into way fill_way of set fill_index, marks that line valid, and sets that set's prediction bit to fill_way. When a fill and a predictor correction reach the same set at the same edge, the fill wins. A lookup accepted at that same edge sees the old contents.
- R3: While req_ready is 1, early_data carries the data stored in the predicted way of set req_index.
- R4: When the predicted way holds a valid line whose tag equals req_tag, resp_valid is 1 in the cycle right after acceptance, with resp_hit=1, resp_slow=0, resp_way set to the predicted way, and resp_data set to that line's data.
- R5: When the predicted way does not match, req_ready is 0 and resp_valid is 0 during the two cycles after acceptance.
- R6: When the other way holds a valid line with a matching tag, the response comes in the third cycle after acceptance, with resp_hit=1, resp_slow=1, resp_way set to the other way, and resp_data set to that line's data.
- R7: After a slow hit, the set's prediction bit points at the way that hit, so the next lookup of the same tag in that set is a fast hit.
- R8: When neither way matches, the response comes in the third cycle after acceptance, with resp_hit=0, resp_slow=1 and resp_data=0. The prediction bit is unchanged.
- R9: A request presented while req_ready is 0 is ignored. It produces no response and changes no state.
- R10: Fast hits can be accepted in back-to-back cycles, giving one response per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_index | input | SET_W | Set selected by the request |
| req_tag | input | TAG_W | Tag to compare |
| req_ready | output | 1 | Stage can accept a request this cycle |
| early_data | output | DATA_W | Predicted way's data for req_index |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_slow | output | 1 | 1 = second probe was needed |
| resp_way | output | 1 | Way that hit |
| resp_data | output | DATA_W | Data of the hitting line, 0 on miss |
| fill_valid | input | 1 | Install a line at this edge |
| fill_index | input | SET_W | Set to install into |
| fill_way | input | 1 | Way to install into |
| fill_tag | input | TAG_W | Tag to install |
| fill_data | input | DATA_W | Data to install |

## Verification
Results arrive at fixed distances from acceptance. A fast hit answers one edge after the request edge. A mispredict holds req_ready low for two edges and answers on the third. The early data output follows the request inputs within the same cycle. The bench's reference model steps once per rising edge, using the same accept, probe and fill order. Outputs are compared 3 ns after each edge, while the inputs driven at the falling edge are still stable. Because of this, a response that comes one cycle early or late is reported as a miscompare at that exact edge.

// File: rtl/waypred_pkg.sv
package waypred_pkg;

    localparam int LK_WAYS = 2;

    typedef enum logic [1:0] {
        LK_IDLE     = 2'd0,
        LK_ALT_READ = 2'd1,
        LK_ALT_CMP  = 2'd2
    } lk_state_e;

endpackage

// File: rtl/waypred_tagcmp.sv
module waypred_tagcmp #(
    parameter int TAG_W = 8
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             match
);

    always_comb begin
        match = line_valid && (line_tag == probe_tag);
    end

endmodule

// File: rtl/waypred_store.sv
module waypred_store
    import waypred_pkg::*;
#(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    // single read port: one way of one set per cycle
    input  logic [SET_W-1:0]  rd_index,
    input  logic              rd_use_pred,
    input  logic              rd_way_sel,
    output logic              rd_way,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    // predictor retrain
    input  logic              upd_en,
    input  logic [SET_W-1:0]  upd_index,
    input  logic              upd_way,
    // line install
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_index,
    input  logic              fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);

    localparam int SETS = 1 << SET_W;

    logic              pred_d [SETS];
    logic              pred_q [SETS];

    logic              way_valid [LK_WAYS];
    logic [TAG_W-1:0]  way_tag   [LK_WAYS];
    logic [DATA_W-1:0] way_data  [LK_WAYS];

    // prediction bits: retrain first, fill overrides
    always_comb begin
        pred_d = pred_q;
        if (upd_en) begin
            pred_d[upd_index] = upd_way;
        end
        if (fill_en) begin
            pred_d[fill_index] = fill_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '{default: 1'b0};
        end else begin
            pred_q <= pred_d;
        end
    end

    for (genvar w = 0; w < LK_WAYS; w++) begin : g_way
        logic              valid_d [SETS];
        logic              valid_q [SETS];
        logic [TAG_W-1:0]  tag_d   [SETS];
        logic [TAG_W-1:0]  tag_q   [SETS];
        logic [DATA_W-1:0] data_d  [SETS];
        logic [DATA_W-1:0] data_q  [SETS];

        always_comb begin
            valid_d = valid_q;
            tag_d   = tag_q;
            data_d  = data_q;
            if (fill_en && (fill_way == 1'(w))) begin
                valid_d[fill_index] = 1'b1;
                tag_d[fill_index]   = fill_tag;
                data_d[fill_index]  = fill_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= '{default: 1'b0};
                tag_q   <= '{default: '0};
                data_q  <= '{default: '0};
            end else begin
                valid_q <= valid_d;
                tag_q   <= tag_d;
                data_q  <= data_d;
            end
        end

        always_comb begin
            way_valid[w] = valid_q[rd_index];
            way_tag[w]   = tag_q[rd_index];
            way_data[w]  = data_q[rd_index];
        end
    end

    always_comb begin
        rd_way   = rd_use_pred ? pred_q[rd_index] : rd_way_sel;
        rd_valid = way_valid[rd_way];
        rd_tag   = way_tag[rd_way];
        rd_data  = way_data[rd_way];
    end

endmodule

// File: rtl/waypred_lookup.sv
module waypred_lookup
    import waypred_pkg::*;
#(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SET_W-1:0]  req_index,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              req_ready,
    output logic [DATA_W-1:0] early_data,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_slow,
    output logic              resp_way,
    output logic [DATA_W-1:0] resp_data,
    input  logic              fill_valid,
    input  logic [SET_W-1:0]  fill_index,
    input  logic              fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);

    typedef struct packed {
        lk_state_e         st;
        logic [SET_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic              alt_way;
        logic              alt_valid;
        logic [TAG_W-1:0]  alt_tag;
        logic [DATA_W-1:0] alt_data;
        logic              rv;
        logic              hit;
        logic              slow;
        logic              way;
        logic [DATA_W-1:0] data;
    } lk_regs_t;

    lk_regs_t r_d, r_q;

    logic              rd_use_pred;
    logic [SET_W-1:0]  rd_index;
    logic              rd_way;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              upd_en;
    logic              cmp_valid;
    logic [TAG_W-1:0]  cmp_line_tag;
    logic [TAG_W-1:0]  cmp_probe_tag;
    logic              cmp_match;

    waypred_store #(
        .SET_W (SET_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_index   (rd_index),
        .rd_use_pred(rd_use_pred),
        .rd_way_sel (r_q.alt_way),
        .rd_way     (rd_way),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_data    (rd_data),
        .upd_en     (upd_en),
        .upd_index  (r_q.idx),
        .upd_way    (r_q.alt_way),
        .fill_en    (fill_valid),
        .fill_index (fill_index),
        .fill_way   (fill_way),
        .fill_tag   (fill_tag),
        .fill_data  (fill_data)
    );

    // the only tag comparator; its inputs depend on the phase
    waypred_tagcmp #(
        .TAG_W(TAG_W)
    ) u_cmp (
        .line_valid(cmp_valid),
        .line_tag  (cmp_line_tag),
        .probe_tag (cmp_probe_tag),
        .match     (cmp_match)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rv      = 1'b0;
        upd_en      = 1'b0;
        rd_use_pred = (r_q.st == LK_IDLE);
        rd_index    = (r_q.st == LK_IDLE) ? req_index : r_q.idx;

        if (r_q.st == LK_ALT_CMP) begin
            cmp_valid     = r_q.alt_valid;
            cmp_line_tag  = r_q.alt_tag;
            cmp_probe_tag = r_q.tag;
        end else begin
            cmp_valid     = rd_valid;
            cmp_line_tag  = rd_tag;
            cmp_probe_tag = req_tag;
        end

        case (r_q.st)
            LK_IDLE: begin
                if (req_valid) begin
                    if (cmp_match) begin
                        r_d.rv   = 1'b1;
                        r_d.hit  = 1'b1;
                        r_d.slow = 1'b0;
                        r_d.way  = rd_way;
                        r_d.data = rd_data;
                    end else begin
                        r_d.st      = LK_ALT_READ;
                        r_d.idx     = req_index;
                        r_d.tag     = req_tag;
                        r_d.alt_way = ~rd_way;
                    end
                end
            end
            LK_ALT_READ: begin
                r_d.alt_valid = rd_valid;
                r_d.alt_tag   = rd_tag;
                r_d.alt_data  = rd_data;
                r_d.st        = LK_ALT_CMP;
            end
            LK_ALT_CMP: begin
                r_d.rv   = 1'b1;
                r_d.hit  = cmp_match;
                r_d.slow = 1'b1;
                r_d.way  = r_q.alt_way;
                r_d.data = cmp_match ? r_q.alt_data : '0;
                upd_en   = cmp_match;
                r_d.st   = LK_IDLE;
            end
            default: begin
                r_d.st = LK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: LK_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready  = (r_q.st == LK_IDLE);
        early_data = rd_data;
        resp_valid = r_q.rv;
        resp_hit   = r_q.hit;
        resp_slow  = r_q.slow;
        resp_way   = r_q.way;
        resp_data  = r_q.data;
    end

endmodule

// File: rtl/waypred_lookup_chk.sv
module waypred_lookup_chk #(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_slow,
    input logic [DATA_W-1:0] resp_data
);

    AST_FAST_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_slow) |-> resp_hit); // R4

    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ((resp_valid && !resp_slow) || !req_ready)); // R4

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !resp_valid); // R5

    AST_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |=> !req_ready); // R5

    AST_SLOW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |=> (req_ready && resp_valid && resp_slow)); // R6

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_slow && (resp_data == '0))); // R8

endmodule

bind waypred_lookup waypred_lookup_chk #(
    .SET_W (SET_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .resp_valid(resp_valid),
    .resp_hit  (resp_hit),
    .resp_slow (resp_slow),
    .resp_data (resp_data)
);

// File: tb/sim_waypred_lookup.sv
`timescale 1ns/1ps
module sim_waypred_lookup;

    localparam int SET_W  = 4;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 16;
    localparam int NSETS  = 1 << SET_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [SET_W-1:0]  req_index = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              req_ready;
    logic [DATA_W-1:0] early_data;
    logic              resp_valid, resp_hit, resp_slow, resp_way;
    logic [DATA_W-1:0] resp_data;
    logic              fill_valid = 1'b0;
    logic [SET_W-1:0]  fill_index = '0;
    logic              fill_way = 1'b0;
    logic [TAG_W-1:0]  fill_tag = '0;
    logic [DATA_W-1:0] fill_data = '0;

    always #5 clk = ~clk;

    waypred_lookup #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_index(req_index), .req_tag(req_tag),
        .req_ready(req_ready), .early_data(early_data),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_slow(resp_slow),
        .resp_way(resp_way), .resp_data(resp_data),
        .fill_valid(fill_valid), .fill_index(fill_index), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_data(fill_data)
    );

    // behavioural reference model
    int m_valid [NSETS][2];
    int m_tag   [NSETS][2];
    int m_data  [NSETS][2];
    int m_pred  [NSETS];
    int busy;
    int pend_idx, pend_tag, pend_alt;
    int snap_v, snap_tag, snap_data;
    int exp_rv, exp_hit, exp_way, exp_slow, exp_data;

    int    nvec = 0;
    int    nfail = 0;
    bit    done = 0;
    string ph = "R1";

    task automatic chk(string req, string field, int act, int expv);
        nvec++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s (phase %s) %s actual %0h expected %0h", req, ph, field, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                m_pred[s] = 0;
                for (int w = 0; w < 2; w++) begin
                    m_valid[s][w] = 0; m_tag[s][w] = 0; m_data[s][w] = 0;
                end
            end
            busy = 0; exp_rv = 0;
        end else begin
            int b;
            b = busy;
            exp_rv = 0;
            if (b == 0 && req_valid) begin
                int i, p;
                i = int'(req_index); p = m_pred[i];
                if (m_valid[i][p] != 0 && m_tag[i][p] == int'(req_tag)) begin
                    exp_rv = 1; exp_hit = 1; exp_slow = 0; exp_way = p; exp_data = m_data[i][p];
                end else begin
                    busy = 2; pend_idx = i; pend_tag = int'(req_tag); pend_alt = 1 - p;
                end
            end else if (b == 2) begin
                snap_v = m_valid[pend_idx][pend_alt];
                snap_tag = m_tag[pend_idx][pend_alt];
                snap_data = m_data[pend_idx][pend_alt];
                busy = 1;
            end else if (b == 1) begin
                exp_rv = 1; exp_slow = 1; exp_way = pend_alt;
                if (snap_v != 0 && snap_tag == pend_tag) begin
                    exp_hit = 1; exp_data = snap_data; m_pred[pend_idx] = pend_alt;
                end else begin
                    exp_hit = 0; exp_data = 0;
                end
                busy = 0;
            end
            if (fill_valid) begin
                m_valid[fill_index][fill_way] = 1;
                m_tag[fill_index][fill_way] = int'(fill_tag);
                m_data[fill_index][fill_way] = int'(fill_data);
                m_pred[fill_index] = int'(fill_way);
            end
        end
    end

    // compare 3 ns after every edge, inputs still stable
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk("R5", "req_ready", int'(req_ready), (busy == 0) ? 1 : 0);
            chk("R5", "resp_valid", int'(resp_valid), exp_rv);
            if (exp_rv != 0) begin
                string r;
                r = (exp_slow == 0) ? "R4" : ((exp_hit != 0) ? "R6" : "R8");
                chk(r, "resp_hit", int'(resp_hit), exp_hit);
                chk(r, "resp_slow", int'(resp_slow), exp_slow);
                chk(r, "resp_data", int'(resp_data), exp_data);
                if (exp_hit != 0) chk(r, "resp_way", int'(resp_way), exp_way);
            end
            if (busy == 0)
                chk("R3", "early_data", int'(early_data), m_data[req_index][m_pred[req_index]]);
        end
    end

    task automatic cyc(bit rv, int idx, int tag, bit fv, int fidx, int fw, int ftag, int fdat);
        @(negedge clk);
        req_valid = rv; req_index = SET_W'(idx); req_tag = TAG_W'(tag);
        fill_valid = fv; fill_index = SET_W'(fidx); fill_way = 1'(fw);
        fill_tag = TAG_W'(ftag); fill_data = DATA_W'(fdat);
    endtask

    task automatic look(int idx, int tag);
        cyc(1, idx, tag, 0, 0, 0, 0, 0);
        while (busy != 0) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(int idx, int w, int tag, int dat);
        cyc(0, 0, 0, 1, idx, w, tag, dat);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired (phase %s)", ph);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, tag 0 must not hit an empty set
        @(posedge clk); #3;
        chk("R1", "req_ready after reset", int'(req_ready), 1);
        chk("R1", "resp_valid after reset", int'(resp_valid), 0);
        look(0, 0);
        look(5, 7);

        ph = "R2";
        fill(1, 0, 8'h11, 16'hA0A0);
        fill(1, 1, 8'h22, 16'hB1B1);
        fill(2, 0, 8'h33, 16'hC2C2);
        idle(1);

        ph = "R4";
        look(1, 8'h22);
        look(2, 8'h33);

        ph = "R6";
        look(1, 8'h11);
        ph = "R7";
        look(1, 8'h11);
        look(1, 8'h11);
        ph = "R8";
        look(1, 8'h55);
        look(1, 8'h11);

        ph = "R9";
        cyc(1, 2, 8'h77, 0, 0, 0, 0, 0);
        cyc(1, 2, 8'h33, 0, 0, 0, 0, 0);
        cyc(1, 1, 8'h22, 0, 0, 0, 0, 0);
        idle(2);
        look(1, 8'h11);

        ph = "R10";
        fill(3, 1, 8'h44, 16'h3131);
        fill(4, 0, 8'h45, 16'h4040);
        for (int k = 0; k < 6; k++)
            cyc(1, (k % 2 == 0) ? 3 : 4, (k % 2 == 0) ? 8'h44 : 8'h45, 0, 0, 0, 0, 0);
        idle(1);

        ph = "R2 same-edge";
        cyc(1, 1, 8'h22, 1, 1, 0, 8'h66, 16'h6666);
        idle(3);
        look(1, 8'h66);

        ph = "mixed";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom);
            cyc(r[0], r[7:4], r[9:8], r[12:11] == 2'b00, r[19:16], r[20], r[22:21], r[31:24] + 1);
        end
        idle(4);
        finish_run();
    end

endmodule